// File: doc/BRIEF.md
# CAN Error and Status Register Logic

This block keeps the error and status word of a CAN controller. The protocol engine gives it the transmit and receive error counter values and a few per-bit monitor signals: the level the node drove, the level sampled from the bus, a sample strobe and three frame-phase qualifiers. From these the block derives two threshold status bits and two warning interrupt flags. It also derives a sticky Bit1 error flag. Five further error types come in as one-cycle pulses and are latched as sticky flags.

Software reads the whole word on `rd_data`. It clears flags by writing a 1 to their bit positions. Warning flag setting is gated by a configuration enable. The two interrupt request lines are gated by per-channel mask inputs.

Register layout of `rd_data` and `wr_data`:
- bit 0: transmit warning interrupt flag
- bit 1: receive warning interrupt flag
- bit 2: transmit warning status
- bit 3: receive warning status
- bit 4: Bit1 error
- bit 5: Bit0 error
- bit 6: ACK error
- bit 7: CRC error
- bit 8: form error
- bit 9: stuff error
- bits 31:10: reserved

Top module: `can_err_status`

## Requirements
- R1: Bit 2 of `rd_data` is 1 exactly while `tx_err_cnt` >= 96, and bit 3 is 1 exactly while `rx_err_cnt` >= 96, in the same cycle as the counter value.
- R2: The transmit warning interrupt flag (bit 0) becomes 1 on the clock edge that ends a cycle in which `warn_en` is 1 and the transmit warning status is 1 while it was 0 in the previous cycle (taken as 0 just after reset). Bit 1 follows the same rule for the receive status. A status that stays high does not set the flag again.
- R3: A cycle with `wr_en`=1 clears, at its closing edge, every interrupt or error flag whose bit in `wr_data` is 1. Flags whose bit is 0 keep their value. With no set event, a flag holds its value.
- R4: `tx_warn_irq` equals bit 0 AND `tx_warn_mask`, and `rx_warn_irq` equals bit 1 AND `rx_warn_mask`, combinationally.
- R5: Bit 4 becomes 1 at the edge ending a cycle with `bit_strobe`=1, `tx_bit`=1 (recessive) and `rx_bit`=0 (dominant). It is not set without the strobe or for any other level pair.
- R6: The R5 set is suppressed while `in_arbitration`, `in_ack_slot` or `in_passive_flag` is 1.
- R7: After reset every bit reads 0 when the counters are below 96. Bits 31:10 always read 0, and writes do not affect bits 2 and 3.
- R8: A 1 on `bit0_err_pulse`, `ack_err_pulse`, `crc_err_pulse`, `form_err_pulse` or `stuff_err_pulse` sets bit 5, 6, 7, 8 or 9 respectively at the closing edge. The bit stays set until cleared as in R3.
- R9: When a set event and a write-1 clear hit the same flag in the same cycle, the flag is 1 afterwards.
- R10: While `warn_en` is 0 the status bits still follow the counters, but no warning flag is set. Raising `warn_en` while a status is already high does not set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_cnt | input | 8 | Transmit error counter value |
| rx_err_cnt | input | 8 | Receive error counter value |
| tx_bit | input | 1 | Level driven by the node (1 = recessive) |
| rx_bit | input | 1 | Level sampled from the bus (1 = recessive) |
| bit_strobe | input | 1 | Marks the cycle in which the sampled bit is valid |
| in_arbitration | input | 1 | Node is in the arbitration field |
| in_ack_slot | input | 1 | Node is in the ACK slot |
| in_passive_flag | input | 1 | Node is sending a passive error flag |
| bit0_err_pulse | input | 1 | Bit0 error event |
| ack_err_pulse | input | 1 | ACK error event |
| crc_err_pulse | input | 1 | CRC error event |
| form_err_pulse | input | 1 | Form error event |
| stuff_err_pulse | input | 1 | Stuff error event |
| warn_en | input | 1 | Enables setting of the warning interrupt flags |
| tx_warn_mask | input | 1 | Mask for the transmit warning request |
| rx_warn_mask | input | 1 | Mask for the receive warning request |
| wr_en | input | 1 | Write strobe for write-1-to-clear |
| wr_data | input | 32 | Write data; a 1 clears the flag at that position |
| rd_data | output | 32 | Register read value |
| tx_warn_irq | output | 1 | Transmit warning interrupt request |
| rx_warn_irq | output | 1 | Receive warning interrupt request |

## Verification
The bench walks the counters across the threshold from 95 to 96 and back. A design that used a level instead of an edge would set the flag again after every clear. The bench also enables warnings while a counter already sits at 100, where a design without a registered previous status would fire a spurious flag. A counter crossing and a write-1 clear are made to fall on the same edge, where a design giving priority to the clear would lose the event. Recessive-sent, dominant-seen bits are applied under each of the three phase qualifiers and without the strobe, so an ungated Bit1 detector shows up as a stray bit 4.

// File: rtl/can_esr_pkg.sv
package can_esr_pkg;
  localparam int REG_W    = 32;
  localparam int CNT_W    = 8;
  localparam int WARN_LIM = 96;
  localparam int POS_TXIF = 0;
  localparam int POS_RXIF = 1;
  localparam int POS_TXST = 2;
  localparam int POS_RXST = 3;
  localparam int POS_ERR0 = 4;   // first of the sticky error flags (Bit1)
  localparam int NUM_ERR  = 6;   // Bit1, Bit0, ACK, CRC, form, stuff
  localparam int USED_W   = POS_ERR0 + NUM_ERR;
endpackage

// File: rtl/esr_warn_chan.sv
module esr_warn_chan #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             warn_en,
  input  logic             clr,
  input  logic             mask,
  output logic             status,
  output logic             flag,
  output logic             irq
);
  logic prev_q;
  logic flag_q, flag_d;
  logic set_evt;

  always_comb begin
    status  = (32'(cnt) >= LIMIT);
    set_evt = warn_en & status & ~prev_q;
    flag_d  = set_evt | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= status;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q & mask;

  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(warn_en && status));
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag_q);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  assert_no_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!warn_en && !flag_q) |=> !flag_q);
endmodule

// File: rtl/esr_sticky_flag.sv
module esr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  assert_sticky_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
endmodule

// File: rtl/esr_bit1_mon.sv
module esr_bit1_mon (
  input  logic tx_bit,
  input  logic rx_bit,
  input  logic strobe,
  input  logic in_arb,
  input  logic in_ack,
  input  logic in_pflag,
  output logic bit1_evt
);
  logic mismatch, blocked;

  always_comb begin
    mismatch = tx_bit & ~rx_bit;
    blocked  = in_arb | in_ack | in_pflag;
    bit1_evt = strobe & mismatch & ~blocked;
  end
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_esr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic             bit_strobe,
  input  logic             in_arbitration,
  input  logic             in_ack_slot,
  input  logic             in_passive_flag,
  input  logic             bit0_err_pulse,
  input  logic             ack_err_pulse,
  input  logic             crc_err_pulse,
  input  logic             form_err_pulse,
  input  logic             stuff_err_pulse,
  input  logic             warn_en,
  input  logic             tx_warn_mask,
  input  logic             rx_warn_mask,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tx_warn_irq,
  output logic             rx_warn_irq
);
  logic [REG_W-1:0]   clr_vec;
  logic [1:0]         w_status, w_flag, w_irq, w_mask;
  logic [CNT_W-1:0]   w_cnt [2];
  logic [NUM_ERR-1:0] err_set, err_flag;
  logic               bit1_evt;
  logic               unused_wr_hi;

  assign clr_vec      = wr_en ? wr_data : '0;
  assign unused_wr_hi = ^wr_data[REG_W-1:USED_W] ^ ^wr_data[POS_RXST:POS_TXST];
  assign w_cnt[0]     = tx_err_cnt;
  assign w_cnt[1]     = rx_err_cnt;
  assign w_mask       = {rx_warn_mask, tx_warn_mask};

  for (genvar c = 0; c < 2; c++) begin : g_warn
    esr_warn_chan #(.CNT_W(CNT_W), .LIMIT(WARN_LIM)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (w_cnt[c]),
      .warn_en (warn_en),
      .clr     (clr_vec[POS_TXIF + c]),
      .mask    (w_mask[c]),
      .status  (w_status[c]),
      .flag    (w_flag[c]),
      .irq     (w_irq[c])
    );
  end

  esr_bit1_mon u_bit1 (
    .tx_bit   (tx_bit),
    .rx_bit   (rx_bit),
    .strobe   (bit_strobe),
    .in_arb   (in_arbitration),
    .in_ack   (in_ack_slot),
    .in_pflag (in_passive_flag),
    .bit1_evt (bit1_evt)
  );

  assign err_set = {stuff_err_pulse, form_err_pulse, crc_err_pulse,
                    ack_err_pulse, bit0_err_pulse, bit1_evt};

  for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
    esr_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set[e]),
      .clr   (clr_vec[POS_ERR0 + e]),
      .flag  (err_flag[e])
    );
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[POS_TXIF]         = w_flag[0];
    rd_data[POS_RXIF]         = w_flag[1];
    rd_data[POS_TXST]         = w_status[0];
    rd_data[POS_RXST]         = w_status[1];
    rd_data[POS_ERR0 +: NUM_ERR] = err_flag;
  end

  assign tx_warn_irq = w_irq[0];
  assign rx_warn_irq = w_irq[1];

  assert_bit1_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && (in_arbitration || in_ack_slot || in_passive_flag)
     && !rd_data[POS_ERR0] && !clr_vec[POS_ERR0]) |=> !rd_data[POS_ERR0]);
  assert_bit1_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[POS_ERR0]) |-> $past(bit_strobe && tx_bit && !rx_bit));
  assert_irq_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_warn_irq |-> tx_warn_mask);
endmodule

// File: tb/can_err_status_test.sv
`timescale 1ns/1ps
module can_err_status_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] tx_err_cnt, rx_err_cnt;
  logic tx_bit, rx_bit, bit_strobe, in_arbitration, in_ack_slot, in_passive_flag;
  logic bit0_err_pulse, ack_err_pulse, crc_err_pulse, form_err_pulse, stuff_err_pulse;
  logic warn_en, tx_warn_mask, rx_warn_mask, wr_en;
  logic [31:0] wr_data, rd_data;
  logic tx_warn_irq, rx_warn_irq;

  int n_checks = 0;
  int n_errors = 0;
  string focus = "R7";

  bit m_prev_tx, m_prev_rx, m_txf, m_rxf;
  bit [5:0] m_err;

  always #5 clk = ~clk;

  can_err_status uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s (phase %s) t=%0t actual=%h expected=%h", tag, focus, $time, act, exp);
    end
  endtask

  task automatic idle();
    tx_bit = 1'b1; rx_bit = 1'b1; bit_strobe = 1'b0;
    in_arbitration = 1'b0; in_ack_slot = 1'b0; in_passive_flag = 1'b0;
    bit0_err_pulse = 1'b0; ack_err_pulse = 1'b0; crc_err_pulse = 1'b0;
    form_err_pulse = 1'b0; stuff_err_pulse = 1'b0;
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Check outputs against the model, then advance model and design one clock.
  task automatic cyc();
    bit txst, rxst, n_txf, n_rxf, b1;
    bit [5:0] n_err, pulses;
    bit [31:0] clr;
    #1;
    txst = (tx_err_cnt >= 8'd96);
    rxst = (rx_err_cnt >= 8'd96);
    chk("R1 tx status", 32'(rd_data[2]), 32'(txst));
    chk("R1 rx status", 32'(rd_data[3]), 32'(rxst));
    chk("R2 R3 R9 R10 warn flags", 32'(rd_data[1:0]), 32'({m_rxf, m_txf}));
    chk("R5 R6 bit1 flag", 32'(rd_data[4]), 32'(m_err[0]));
    chk("R8 error flags", 32'(rd_data[9:5]), 32'(m_err[5:1]));
    chk("R7 reserved", rd_data[31:10], 32'd0);
    chk("R4 irq", 32'({rx_warn_irq, tx_warn_irq}),
        32'({m_rxf & rx_warn_mask, m_txf & tx_warn_mask}));
    clr = wr_en ? wr_data : 32'd0;
    n_txf = m_txf; n_rxf = m_rxf;
    if (clr[0]) n_txf = 1'b0;
    if (clr[1]) n_rxf = 1'b0;
    if (warn_en && txst && !m_prev_tx) n_txf = 1'b1;
    if (warn_en && rxst && !m_prev_rx) n_rxf = 1'b1;
    b1 = bit_strobe && tx_bit && !rx_bit &&
         !(in_arbitration || in_ack_slot || in_passive_flag);
    pulses = {stuff_err_pulse, form_err_pulse, crc_err_pulse, ack_err_pulse, bit0_err_pulse, b1};
    for (int i = 0; i < 6; i++) begin
      n_err[i] = m_err[i];
      if (clr[4+i]) n_err[i] = 1'b0;
      if (pulses[i]) n_err[i] = 1'b1;
    end
    @(posedge clk);
    if (!rst_n) begin
      m_prev_tx = 0; m_prev_rx = 0; m_txf = 0; m_rxf = 0; m_err = '0;
    end else begin
      m_prev_tx = txst; m_prev_rx = rxst; m_txf = n_txf; m_rxf = n_rxf; m_err = n_err;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic write1(logic [31:0] d);
    wr_en = 1'b1; wr_data = d; cyc();
  endtask

  task automatic strobe_bit(logic t, logic r, logic a, logic k, logic p);
    tx_bit = t; rx_bit = r; bit_strobe = 1'b1;
    in_arbitration = a; in_ack_slot = k; in_passive_flag = p;
    cyc();
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    idle();
    tx_err_cnt = 0; rx_err_cnt = 0;
    warn_en = 1'b1; tx_warn_mask = 1'b1; rx_warn_mask = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    focus = "R7";
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    focus = "R1 R2";
    for (int v = 93; v <= 98; v++) begin tx_err_cnt = 8'(v); rx_err_cnt = 8'(v - 1); cyc(); end
    tx_err_cnt = 100; rx_err_cnt = 100; repeat (3) cyc();

    focus = "R3";
    write1(32'h0000_0000);
    write1(32'h0000_0001);
    repeat (3) cyc();
    write1(32'hFFFF_FFFE);
    repeat (2) cyc();

    focus = "R2";
    tx_err_cnt = 95; cyc();
    tx_err_cnt = 96; cyc(); cyc();

    focus = "R9";
    tx_err_cnt = 95; rx_err_cnt = 95; write1(32'h3);
    tx_err_cnt = 96; rx_err_cnt = 96; write1(32'h3);
    cyc(); cyc();
    write1(32'h3); cyc();

    focus = "R10";
    warn_en = 1'b0;
    tx_err_cnt = 80; rx_err_cnt = 80; cyc();
    tx_err_cnt = 100; rx_err_cnt = 120; repeat (2) cyc();
    warn_en = 1'b1; repeat (3) cyc();
    tx_err_cnt = 90; cyc(); tx_err_cnt = 97; repeat (2) cyc();

    focus = "R4";
    tx_warn_mask = 1'b0; cyc();
    rx_warn_mask = 1'b0; cyc();
    tx_warn_mask = 1'b1; rx_warn_mask = 1'b1; cyc();

    focus = "R6";
    strobe_bit(1, 0, 1, 0, 0); cyc();
    strobe_bit(1, 0, 0, 1, 0); cyc();
    strobe_bit(1, 0, 0, 0, 1); cyc();
    focus = "R5";
    tx_bit = 1'b1; rx_bit = 1'b0; cyc(); cyc();
    strobe_bit(0, 1, 0, 0, 0); cyc();
    strobe_bit(0, 0, 0, 0, 0);
    strobe_bit(1, 1, 0, 0, 0); cyc();
    strobe_bit(1, 0, 0, 0, 0); cyc(); cyc();
    write1(32'h10); cyc();

    focus = "R8";
    bit0_err_pulse = 1; cyc();
    ack_err_pulse = 1; crc_err_pulse = 1; cyc();
    form_err_pulse = 1; cyc();
    stuff_err_pulse = 1; cyc(); cyc();
    write1(32'h0000_0140); cyc();
    focus = "R9";
    bit0_err_pulse = 1; write1(32'h0000_0020); cyc();
    focus = "R7";
    write1(32'hFFFF_FFFF); cyc();

    focus = "random";
    for (int i = 0; i < 400; i++) begin
      tx_err_cnt = 8'(90 + $urandom_range(0, 12));
      rx_err_cnt = 8'(90 + $urandom_range(0, 12));
      warn_en = ($urandom_range(0, 3) != 0);
      tx_warn_mask = 1'($urandom_range(0, 1));
      rx_warn_mask = 1'($urandom_range(0, 1));
      tx_bit = 1'($urandom_range(0, 1));
      rx_bit = 1'($urandom_range(0, 1));
      bit_strobe = 1'($urandom_range(0, 1));
      in_arbitration = ($urandom_range(0, 3) == 0);
      in_ack_slot = ($urandom_range(0, 3) == 0);
      in_passive_flag = ($urandom_range(0, 3) == 0);
      bit0_err_pulse = ($urandom_range(0, 7) == 0);
      ack_err_pulse = ($urandom_range(0, 7) == 0);
      crc_err_pulse = ($urandom_range(0, 7) == 0);
      form_err_pulse = ($urandom_range(0, 7) == 0);
      stuff_err_pulse = ($urandom_range(0, 7) == 0);
      wr_en = ($urandom_range(0, 2) == 0);
      wr_data = $urandom();
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule